// File: doc/BRIEF.md
# Interlace-Capable Vertical Timing Generator

This block keeps track of the vertical position inside a video frame and produces the vertical blanking and vertical sync levels from it. A horizontal timing generator supplies a strobe at the start of every line, a strobe at the middle of every line, and single-cycle marks at the leading edges of its horizontal blanking and horizontal sync pulses. The block counts one position per line in progressive mode. In interlaced mode it counts one position per half-line. It compares that position against four programmed limits, which are always expressed per frame.

The position counter starts at 1 and runs up to a frame limit, then restarts at 1. In progressive mode that limit is the programmed line count. In interlaced mode it is twice that count, so one frame spans two fields of half-lines. The blanking, sync-start and sync-end limits include the +1 for the first counted position. The frame-length limit has no such offset. Vertical blanking may change only on a horizontal blanking leading edge. Vertical sync may change only on a horizontal sync leading edge. The block also provides a field indicator and a one-cycle frame-start pulse.

Top module: `vtg_vertical`

## Requirements
- R1: After reset the position is 1. Each counting step raises it by one while it is below the frame limit. A step taken at the frame limit returns it to 1, so a frame lasts exactly frame-limit steps.
- R2: With `interlace_en` low, only `line_start` is a counting step. `half_line` pulses have no effect on any output.
- R3: With `interlace_en` high, both `line_start` and `half_line` are counting steps, and the frame limit is 2 × `frame_lines_i`.
- R4: In a cycle with `hblank_lead` high, `vblank_o` is loaded with (P < `blank_end_i`). Here P is the position after any step taken in that same cycle. In every other cycle `vblank_o` holds its value.
- R5: In a cycle with `hsync_lead` high, `vsync_o` is loaded with (`porch_end_i` ≤ P < `sync_end_i`). P is defined as in R4. In every other cycle `vsync_o` holds its value.
- R6: `frame_start_o` is high for exactly the one cycle after a step that returned the position to 1. It is low otherwise.
- R7: `field_odd_o` is 1 while `interlace_en` is high and the position exceeds `frame_lines_i`. It is 0 otherwise, and always 0 in progressive mode.
- R8: During and right after reset, `vblank_o`, `vsync_o`, `frame_start_o` and `field_odd_o` are 0.
- R9: If the limits are reprogrammed so that the position is already at or above the new frame limit, the next step returns the position to 1 and raises `frame_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interlace_en | input | 1 | 1 = interlaced, half-line counting |
| line_start | input | 1 | Strobe at the start of each line |
| half_line | input | 1 | Strobe at the middle of each line |
| hblank_lead | input | 1 | Leading edge mark of horizontal blanking |
| hsync_lead | input | 1 | Leading edge mark of horizontal sync |
| porch_end_i | input | RW | Position where sync begins (front porch + 1) |
| sync_end_i | input | RW | Position where sync ends |
| blank_end_i | input | RW | Position where blanking ends (width + 1) |
| frame_lines_i | input | RW | Whole lines per frame, no offset |
| vblank_o | output | 1 | Vertical blanking, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| field_odd_o | output | 1 | Second-field indicator |
| frame_start_o | output | 1 | One-cycle pulse at each frame restart |

## Verification
The bench builds the block with RW = 6, so its frames are only 7 lines long and the counter is 7 bits wide. At that size many full frames fit in both modes. This covers the wrap in progressive and in interlaced counting, the half-frame field change, and limits shrunk below the current position. Half-line strobes with and without the interlace flag, and line steps without blanking or sync edges, separate the counting step from the output gating.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Frame limit in counting steps: doubled for half-line counting.
  function automatic int unsigned frame_limit(input logic il, input int unsigned lines);
    return il ? (lines * 2) : lines;
  endfunction

  // Position after a step decision; restarts at 1 at or above the limit.
  function automatic int unsigned advance(input logic step, input int unsigned pos,
                                          input int unsigned lim);
    if (!step) return pos;
    return (pos >= lim) ? 1 : pos + 1;
  endfunction

  function automatic logic blank_zone(input int unsigned pos, input int unsigned stop);
    return pos < stop;
  endfunction

  function automatic logic sync_zone(input int unsigned pos, input int unsigned first,
                                     input int unsigned stop);
    return (pos >= first) && (pos < stop);
  endfunction

endpackage

// File: rtl/vtg_line_counter.sv
module vtg_line_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] pos_q,
  output logic [CW-1:0] pos_nxt,
  output logic          wrap_q
);
  import vtg_pkg::*;

  logic wrap_now;

  always_comb begin
    pos_nxt  = CW'(advance(step, 32'(pos_q), 32'(limit)));
    wrap_now = step && (pos_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= CW'(1);
      wrap_q <= 1'b0;
    end else begin
      pos_q  <= pos_nxt;
      wrap_q <= wrap_now;
    end
  end
endmodule

// File: rtl/vtg_edge_hold.sv
module vtg_edge_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/vtg_vertical.sv
module vtg_vertical #(
  parameter int RW = 11,
  localparam int CW = RW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          interlace_en,
  input  logic          line_start,
  input  logic          half_line,
  input  logic          hblank_lead,
  input  logic          hsync_lead,
  input  logic [RW-1:0] porch_end_i,
  input  logic [RW-1:0] sync_end_i,
  input  logic [RW-1:0] blank_end_i,
  input  logic [RW-1:0] frame_lines_i,
  output logic          vblank_o,
  output logic          vsync_o,
  output logic          field_odd_o,
  output logic          frame_start_o
);
  import vtg_pkg::*;

  // Named internal events, observed by the bound checker.
  logic          step_w;
  logic [CW-1:0] vmax_w;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          blank_d;
  logic          sync_d;

  always_comb begin
    step_w  = line_start || (interlace_en && half_line);
    vmax_w  = CW'(frame_limit(interlace_en, 32'(frame_lines_i)));
    blank_d = blank_zone(32'(cnt_nxt), 32'(blank_end_i));
    sync_d  = sync_zone(32'(cnt_nxt), 32'(porch_end_i), 32'(sync_end_i));
  end

  vtg_line_counter #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step_w),
    .limit   (vmax_w),
    .pos_q   (cnt_q),
    .pos_nxt (cnt_nxt),
    .wrap_q  (frame_start_o)
  );

  vtg_edge_hold u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hblank_lead),
    .d     (blank_d),
    .q     (vblank_o)
  );

  vtg_edge_hold u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hsync_lead),
    .d     (sync_d),
    .q     (vsync_o)
  );

  assign field_odd_o = interlace_en && (cnt_q > {1'b0, frame_lines_i});
endmodule

// File: rtl/vtg_vertical_chk.sv
module vtg_vertical_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          interlace_en,
  input logic          line_start,
  input logic          half_line,
  input logic          hblank_lead,
  input logic          hsync_lead,
  input logic          step_w,
  input logic [CW-1:0] vmax_w,
  input logic [CW-1:0] cnt_q,
  input logic          vblank_o,
  input logic          vsync_o,
  input logic          field_odd_o,
  input logic          frame_start_o
);
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_w && (cnt_q < vmax_w) |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_w |=> $stable(cnt_q)); // R2
  AST_PROG_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace_en && !line_start |-> !step_w); // R2
  AST_IL_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    interlace_en && half_line |-> step_w); // R3
  AST_VBLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hblank_lead |=> $stable(vblank_o)); // R4
  AST_VSYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_lead |=> $stable(vsync_o)); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_w && (cnt_q >= vmax_w) |=> (cnt_q == CW'(1)) && frame_start_o); // R9
  AST_FS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> cnt_q == CW'(1)); // R6
  AST_FIELD_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace_en |-> !field_odd_o); // R7
endmodule

bind vtg_vertical vtg_vertical_chk #(.CW(CW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .interlace_en  (interlace_en),
  .line_start    (line_start),
  .half_line     (half_line),
  .hblank_lead   (hblank_lead),
  .hsync_lead    (hsync_lead),
  .step_w        (step_w),
  .vmax_w        (vmax_w),
  .cnt_q         (cnt_q),
  .vblank_o      (vblank_o),
  .vsync_o       (vsync_o),
  .field_odd_o   (field_odd_o),
  .frame_start_o (frame_start_o)
);

// File: tb/vtg_vertical_tb.sv
module vtg_vertical_tb_top;
  localparam int RW = 6;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic il = 1'b0, ls = 1'b0, hl = 1'b0, hb = 1'b0, hs = 1'b0;
  logic [RW-1:0] r5 = 3, r6 = 5, r7 = 6, r8 = 7;
  logic vblank, vsync, field, fstart;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model state
  int m_pos = 1;
  bit m_vb = 0, m_vs = 0, m_fs = 0;
  int steps = 0;
  int exp_period = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_vertical #(.RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .interlace_en(il), .line_start(ls), .half_line(hl),
    .hblank_lead(hb), .hsync_lead(hs), .porch_end_i(r5), .sync_end_i(r6),
    .blank_end_i(r7), .frame_lines_i(r8), .vblank_o(vblank), .vsync_o(vsync),
    .field_odd_o(field), .frame_start_o(fstart)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ls = 0; hl = 0; hb = 0; hs = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(vblank, 0, "R8 vblank in reset");
    chk(vsync, 0, "R8 vsync in reset");
    chk(fstart, 0, "R8 frame_start in reset");
    chk(field, 0, "R8 field in reset");
    @(negedge clk);
    rst_n = 1;
    m_pos = 1; m_vb = 0; m_vs = 0; m_fs = 0; steps = 0;
  endtask

  // One clock with the given strobes; compares every output to the model.
  task automatic tick(input bit a_ls, input bit a_hl, input bit a_hb, input bit a_hs);
    int lim, nxt;
    bit st;
    @(negedge clk);
    ls = a_ls; hl = a_hl; hb = a_hb; hs = a_hs;
    @(posedge clk);
    #1;
    st  = a_ls || (il && a_hl);
    lim = il ? 2 * int'(r8) : int'(r8);
    nxt = st ? ((m_pos >= lim) ? 1 : m_pos + 1) : m_pos;
    m_fs = st && (m_pos >= lim);
    if (a_hb) m_vb = (nxt < int'(r7));
    if (a_hs) m_vs = (nxt >= int'(r5)) && (nxt < int'(r6));
    m_pos = nxt;
    if (st) steps++;
    chk(vblank, m_vb, "R4 vblank");
    chk(vsync, m_vs, "R5 vsync");
    chk(fstart, m_fs, "R6 frame_start");
    chk(field, (il && (m_pos > int'(r8))) ? 1 : 0, "R7 field");
    if (fstart) begin
      if (exp_period != 0) chk(steps, exp_period, "R1 steps per frame");
      steps = 0;
    end
  endtask

  task automatic line_prog();
    tick(1, 0, 1, 1); tick(0, 0, 0, 0); tick(0, 1, 0, 0); tick(0, 0, 0, 0);
  endtask

  task automatic line_il();
    tick(1, 0, 1, 1); tick(0, 0, 0, 0); tick(0, 1, 1, 1); tick(0, 0, 0, 0);
  endtask

  task automatic t_progressive();
    il = 0; r5 = 3; r6 = 5; r7 = 6; r8 = 7; exp_period = 7;
    do_reset();
    for (int i = 0; i < 3 * 7; i++) line_prog();
    chk(steps, 0, "R1 three whole frames end on a wrap");
  endtask

  task automatic t_half_ignored();
    bit vb0, vs0;
    il = 0; r5 = 3; r6 = 5; r7 = 6; r8 = 7; exp_period = 7;
    do_reset();
    for (int i = 0; i < 3; i++) line_prog();
    vb0 = vblank; vs0 = vsync;
    chk(vs0, 1, "R5 sync active at position 4");
    for (int i = 0; i < 20; i++) begin
      tick(0, 1, 1, 1);
      chk(fstart, 0, "R2 half_line gives no frame start");
      chk(vblank, vb0, "R2 half_line leaves vblank");
      chk(vsync, vs0, "R2 half_line leaves vsync");
    end
    tick(1, 0, 1, 1);
    chk(vsync, 0, "R2 next line reaches position 5, sync ends");
  endtask

  task automatic t_interlaced();
    il = 1; r5 = 3; r6 = 6; r7 = 9; r8 = 7; exp_period = 14;
    do_reset();
    for (int i = 0; i < 3 * 7; i++) line_il();
    chk(steps, 0, "R3 frames of 2x lines half-line steps");
    for (int i = 0; i < 4; i++) line_il();
    chk(field, 1, "R7 second field after half frame");
  endtask

  task automatic t_gating();
    bit vb0;
    il = 0; r5 = 3; r6 = 5; r7 = 6; r8 = 7; exp_period = 7;
    do_reset();
    tick(1, 0, 1, 0);
    vb0 = vblank;
    chk(vb0, 1, "R4 blank at position 2");
    for (int i = 0; i < 5; i++) tick(1, 0, 0, 0);
    chk(vblank, vb0, "R4 vblank held without hblank edge");
    chk(vsync, 0, "R5 vsync held without hsync edge");
    tick(0, 0, 1, 0);
    chk(vblank, 0, "R4 vblank drops on hblank edge at position 7");
  endtask

  task automatic t_shrink();
    il = 0; r5 = 3; r6 = 5; r7 = 6; r8 = 7; exp_period = 0;
    do_reset();
    for (int i = 0; i < 5; i++) line_prog();
    @(negedge clk);
    r8 = 3;
    tick(1, 0, 1, 1);
    chk(fstart, 1, "R9 restart after limit shrinks");
    chk(vblank, 1, "R9 position back to 1 is blanked");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..R9 run) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_progressive();
    t_half_ignored();
    t_interlaced();
    t_gating();
    t_shrink();
    do_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule